// File: doc/BRIEF.md
# Complementary PWM Dead-Time and Brake Output Stage

This block turns a shared timer count into gated complementary output pairs for a set of PWM channels. For each channel a reference level is formed by comparing the count against that channel's compare value. A main pin and a complementary pin are derived from the reference. A programmable dead gap separates the switch-off of one pin from the switch-on of the other. Each pin has its own polarity bit.

Two brake inputs guard the outputs. Each brake input has a polarity select and a debounce filter. A qualified brake forces every pin to its programmed safe level straight away. It also clears the master output enable. The enable comes back in one of two ways: by a software set pulse, or, when the automatic option is on, at the next counter update event once no brake is active.

Separate off-state settings decide what the pins do in two situations. One applies while the master enable is low. The other applies while the master enable is high but a channel is switched off. In each case a pin is either driven to a defined level or has its pin enable released.

Top module: `cpwm_dtb_unit`

## Requirements
- R1: A channel's reference is high while the count is below that channel's compare value (unsigned). The main pin is active while the reference is high and the complementary pin is active while it is low. The reference is registered, so a count change shows at the pins after one clock edge.
- R2: On every reference edge, the output turning off goes inactive at once. The output turning on stays inactive for dt × 2^psc clock cycles, where dt is the 10-bit dead-time field and psc is the 2-bit dead-time prescale field.
- R3: If the reference returns before the dead gap ends, the output that was due to turn on stays inactive for the whole pulse.
- R4: A polarity bit of 1 makes that pin active-low: the pin level is the active-high level XOR the polarity bit. This applies separately to the main pin and the complementary pin of each channel.
- R5: A brake input qualifies after N consecutive clock samples at its active level. N is that brake's filter field, and a field of 0 means 1. Any inactive sample restarts the run and releases the brake.
- R6: A brake polarity bit of 1 makes low the active level of that brake input. A bit of 0 makes high the active level.
- R7: In the cycle a brake qualifies, all pins take their safe levels. The master enable is cleared at the next edge, so the pins stay safe after the brake releases.
- R8: The master enable is set by the software set pulse only while no brake is qualified. When the automatic option is 1, it is also set by an update pulse while no brake is qualified. When the automatic option is 0, the update pulse has no effect.
- R9: While the master enable is low, every pin shows its safe level. Its pin enable equals the idle off-state bit.
- R10: While the master enable is high and a channel is disabled, that channel's pins show their inactive level (equal to the polarity bit). Their pin enables equal the run off-state bit.
- R11: After reset the master enable is low and the dead-time state is cleared, so the pins follow R9.
- R12: Channels are independent: each uses only its own compare value and polarity and safe-level bits. The dead-time setting is shared by all channels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_i | input | CNT_W | Timer count value |
| cmp_i | input | NCH*CNT_W | Compare values, channel 0 in the low bits |
| upd_i | input | 1 | Counter update event pulse |
| ch_en_i | input | NCH | Channel enable |
| pol_main_i | input | NCH | Main pin polarity, 1 = active low |
| pol_comp_i | input | NCH | Complementary pin polarity, 1 = active low |
| idle_main_i | input | NCH | Safe level of main pins |
| idle_comp_i | input | NCH | Safe level of complementary pins |
| off_run_i | input | 1 | Drive disabled channels while enabled (1) or release them (0) |
| off_idle_i | input | 1 | Drive safe levels while master enable is low (1) or release (0) |
| dt_i | input | DT_W | Dead-time ticks |
| dt_psc_i | input | PSC_W | Dead-time tick prescale, tick = 2^psc cycles |
| brk_i | input | NBRK | Brake inputs |
| brk_pol_i | input | NBRK | Brake polarity, 1 = active low |
| brk_flt_i | input | NBRK*FLT_W | Brake filter lengths, brake 0 in the low bits |
| moe_set_i | input | 1 | Software set pulse for the master enable |
| auto_oe_i | input | 1 | Automatic re-enable at update events |
| main_o | output | NCH | Main pin levels |
| comp_o | output | NCH | Complementary pin levels |
| main_en_o | output | NCH | Main pin drive enables |
| comp_en_o | output | NCH | Complementary pin drive enables |

## Verification
The count is stepped across three compare values at once, one of them zero. This separates a per-channel compare from a shared one, and it also exposes a strict-versus-inclusive comparison. Dead time is tried both with and without the prescale: a gap counted in raw ticks ends in a different cycle from one scaled by 2^psc. Short pulses are used to show that no output turns on during the pulse. Brake runs interrupted by a single inactive sample, together with an active-low brake, show whether the filter really counts consecutive samples and whether it honours polarity. Update pulses sent with the automatic option off, with it on, and while a brake is active separate the three re-enable paths.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
  localparam int unsigned DEF_NCH   = 3;
  localparam int unsigned DEF_NBRK  = 2;
  localparam int unsigned DEF_CNT_W = 16;
  localparam int unsigned DEF_DT_W  = 10;
  localparam int unsigned DEF_PSC_W = 2;
  localparam int unsigned DEF_FLT_W = 4;

  typedef struct packed {
    logic lvl;
    logic en;
  } pin_t;

  function automatic pin_t pin_sel(input logic brk_or_off, input logic ch_on,
                                   input logic act, input logic pol,
                                   input logic idle, input logic off_idle,
                                   input logic off_run);
    pin_t p;
    if (brk_or_off) begin
      p.lvl = idle;
      p.en  = off_idle;
    end else if (!ch_on) begin
      p.lvl = pol;
      p.en  = off_run;
    end else begin
      p.lvl = act ^ pol;
      p.en  = 1'b1;
    end
    return p;
  endfunction
endpackage

// File: rtl/cpwm_deadtime.sv
module cpwm_deadtime #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned DT_W  = 10,
  parameter int unsigned PSC_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic [DT_W-1:0]  dt_i,
  input  logic [PSC_W-1:0] dt_psc_i,
  output logic             main_o,
  output logic             comp_o
);
  localparam int unsigned DLY_W = DT_W + (1 << PSC_W) - 1;

  logic             ref_d, ref_q;
  logic [DLY_W-1:0] dly, dcnt_q;

  assign ref_d = (cnt_i < cmp_i);
  assign dly   = DLY_W'(dt_i) << dt_psc_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q  <= 1'b0;
      dcnt_q <= '0;
    end else begin
      ref_q <= ref_d;
      if (ref_d != ref_q)        dcnt_q <= dly;
      else if (dcnt_q != '0)     dcnt_q <= dcnt_q - 1'b1;
    end
  end

  // both outputs wait out the gap; the leaving one drops with ref_q
  assign main_o = ref_q  && (dcnt_q == '0);
  assign comp_o = !ref_q && (dcnt_q == '0);

  a_r2_gap_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(ref_q) && $past(dly) != '0) |-> !main_o);
  a_r2_gap_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(ref_q) && $past(dly) != '0) |-> !comp_o);
  a_r1_main_follows_ref: assert property (@(posedge clk_i) disable iff (!rst_ni)
    main_o |-> $past(ref_d));
endmodule

// File: rtl/cpwm_brk_filter.sv
module cpwm_brk_filter #(
  parameter int unsigned FLT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             brk_i,
  input  logic             pol_i,
  input  logic [FLT_W-1:0] flt_i,
  output logic             act_o
);
  logic             act_s;
  logic [FLT_W-1:0] run_q, run_nxt, need;

  assign act_s   = brk_i ^ pol_i;
  assign run_nxt = (run_q == '1) ? run_q : run_q + 1'b1;
  assign need    = (flt_i == '0) ? FLT_W'(1) : flt_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= '0;
      act_o <= 1'b0;
    end else if (!act_s) begin
      run_q <= '0;
      act_o <= 1'b0;
    end else begin
      run_q <= run_nxt;
      act_o <= (run_nxt >= need);
    end
  end

  a_r5_rise_needs_sample: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(act_o) |-> $past(act_s));
  a_r5_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !act_s |=> !act_o);
endmodule

// File: rtl/cpwm_moe_ctrl.sv
module cpwm_moe_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic brk_i,
  input  logic set_i,
  input  logic auto_i,
  input  logic upd_i,
  output logic moe_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                moe_o <= 1'b0;
    else if (brk_i)             moe_o <= 1'b0;
    else if (set_i)             moe_o <= 1'b1;
    else if (auto_i && upd_i)   moe_o <= 1'b1;
  end

  a_r7_brake_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_i |=> !moe_o);
  a_r8_set_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(moe_o) |-> $past(set_i || (auto_i && upd_i)));
endmodule

// File: rtl/cpwm_dtb_unit.sv
module cpwm_dtb_unit
  import cpwm_pkg::*;
#(
  parameter int unsigned NCH   = DEF_NCH,
  parameter int unsigned NBRK  = DEF_NBRK,
  parameter int unsigned CNT_W = DEF_CNT_W,
  parameter int unsigned DT_W  = DEF_DT_W,
  parameter int unsigned PSC_W = DEF_PSC_W,
  parameter int unsigned FLT_W = DEF_FLT_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [CNT_W-1:0]      cnt_i,
  input  logic [NCH*CNT_W-1:0]  cmp_i,
  input  logic                  upd_i,
  input  logic [NCH-1:0]        ch_en_i,
  input  logic [NCH-1:0]        pol_main_i,
  input  logic [NCH-1:0]        pol_comp_i,
  input  logic [NCH-1:0]        idle_main_i,
  input  logic [NCH-1:0]        idle_comp_i,
  input  logic                  off_run_i,
  input  logic                  off_idle_i,
  input  logic [DT_W-1:0]       dt_i,
  input  logic [PSC_W-1:0]      dt_psc_i,
  input  logic [NBRK-1:0]       brk_i,
  input  logic [NBRK-1:0]       brk_pol_i,
  input  logic [NBRK*FLT_W-1:0] brk_flt_i,
  input  logic                  moe_set_i,
  input  logic                  auto_oe_i,
  output logic [NCH-1:0]        main_o,
  output logic [NCH-1:0]        comp_o,
  output logic [NCH-1:0]        main_en_o,
  output logic [NCH-1:0]        comp_en_o
);
  logic [NBRK-1:0] brk_act;
  logic [NCH-1:0]  raw_main, raw_comp;
  logic            brk_any, moe, force_safe;

  for (genvar b = 0; b < NBRK; b++) begin : g_brk
    cpwm_brk_filter #(.FLT_W(FLT_W)) i_flt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .brk_i (brk_i[b]),
      .pol_i (brk_pol_i[b]),
      .flt_i (brk_flt_i[b*FLT_W +: FLT_W]),
      .act_o (brk_act[b])
    );
  end

  assign brk_any = |brk_act;

  cpwm_moe_ctrl i_moe (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .brk_i (brk_any),
    .set_i (moe_set_i),
    .auto_i(auto_oe_i),
    .upd_i (upd_i),
    .moe_o (moe)
  );

  // brake overrides without waiting for the enable register
  assign force_safe = brk_any || !moe;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    pin_t pm, pc;

    cpwm_deadtime #(.CNT_W(CNT_W), .DT_W(DT_W), .PSC_W(PSC_W)) i_dt (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .cnt_i   (cnt_i),
      .cmp_i   (cmp_i[c*CNT_W +: CNT_W]),
      .dt_i    (dt_i),
      .dt_psc_i(dt_psc_i),
      .main_o  (raw_main[c]),
      .comp_o  (raw_comp[c])
    );

    always_comb begin
      pm = pin_sel(force_safe, ch_en_i[c], raw_main[c], pol_main_i[c],
                   idle_main_i[c], off_idle_i, off_run_i);
      pc = pin_sel(force_safe, ch_en_i[c], raw_comp[c], pol_comp_i[c],
                   idle_comp_i[c], off_idle_i, off_run_i);
    end

    assign main_o[c]    = pm.lvl;
    assign main_en_o[c] = pm.en;
    assign comp_o[c]    = pc.lvl;
    assign comp_en_o[c] = pc.en;

    a_r1_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!force_safe && ch_en_i[c]) |->
        !((main_o[c] ^ pol_main_i[c]) && (comp_o[c] ^ pol_comp_i[c])));
    a_r7_safe_levels: assert property (@(posedge clk_i) disable iff (!rst_ni)
      brk_act != '0 |-> (main_o[c] == idle_main_i[c] && comp_o[c] == idle_comp_i[c]));
  end
endmodule

// File: tb/test_cpwm_dtb_unit.sv
module test_cpwm_dtb_unit;
  localparam int NCH = 3, NBRK = 2, CNT_W = 16, DT_W = 10, PSC_W = 2, FLT_W = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [CNT_W-1:0] cnt = '0;
  logic [NCH*CNT_W-1:0] cmp = '0;
  logic upd = 1'b0;
  logic [NCH-1:0] ch_en = '0, pol_m = '0, pol_c = '0, idle_m = 3'b101, idle_c = 3'b010;
  logic off_run = 1'b1, off_idle = 1'b1;
  logic [DT_W-1:0] dt = '0;
  logic [PSC_W-1:0] psc = '0;
  logic [NBRK-1:0] brk = '0, brk_pol = '0;
  logic [NBRK*FLT_W-1:0] brk_flt = '0;
  logic moe_set = 1'b0, auto_oe = 1'b0;
  logic [NCH-1:0] main_o, comp_o, men, cen;
  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cpwm_dtb_unit i_cpwm_dtb_unit (
    .clk_i(clk), .rst_ni(rst_ni), .cnt_i(cnt), .cmp_i(cmp), .upd_i(upd),
    .ch_en_i(ch_en), .pol_main_i(pol_m), .pol_comp_i(pol_c),
    .idle_main_i(idle_m), .idle_comp_i(idle_c), .off_run_i(off_run),
    .off_idle_i(off_idle), .dt_i(dt), .dt_psc_i(psc), .brk_i(brk),
    .brk_pol_i(brk_pol), .brk_flt_i(brk_flt), .moe_set_i(moe_set),
    .auto_oe_i(auto_oe), .main_o(main_o), .comp_o(comp_o),
    .main_en_o(men), .comp_en_o(cen)
  );

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_moe();
    moe_set = 1'b1; tick(); moe_set = 1'b0;
  endtask

  task automatic t_reset();
    chk("R11 main safe", main_o, 3'b101);
    chk("R11 comp safe", comp_o, 3'b010);
    chk("R9 en idle=1", {men, cen}, 6'b111111);
    off_idle = 1'b0; #1;
    chk("R9 en idle=0", {men, cen}, 6'b000000);
    chk("R9 level kept", main_o, 3'b101);
    off_idle = 1'b1;
  endtask

  task automatic t_pwm();
    ch_en = 3'b111;
    cmp = {16'd0, 16'd10, 16'd5};
    cnt = 16'd3;
    pulse_moe();
    chk("R1 R12 main cnt=3", main_o, 3'b011);
    chk("R1 R12 comp cnt=3", comp_o, 3'b100);
    cnt = 16'd7; tick();
    chk("R1 main cnt=7", main_o, 3'b010);
    chk("R1 comp cnt=7", comp_o, 3'b101);
    cnt = 16'd10; tick();
    chk("R1 main cnt=cmp", main_o, 3'b000);
    chk("R1 comp cnt=cmp", comp_o, 3'b111);
  endtask

  task automatic t_deadtime();
    cnt = 16'd20; tick(3);
    dt = 10'd3; psc = 2'd1;
    cnt = 16'd0; tick();
    chk("R2 rise both off", {main_o[0], comp_o[0]}, 2'b00);
    tick(5);
    chk("R2 main held 5", main_o[0], 1'b0);
    tick();
    chk("R2 main on at 6", main_o[0], 1'b1);
    cnt = 16'd20; tick();
    chk("R2 fall both off", {main_o[0], comp_o[0]}, 2'b00);
    tick(5);
    chk("R2 comp held 5", comp_o[0], 1'b0);
    tick();
    chk("R2 comp on at 6", comp_o[0], 1'b1);
    dt = 10'd2; psc = 2'd0;
    cnt = 16'd0; tick(2);
    chk("R2 psc0 held", main_o[0], 1'b0);
    tick();
    chk("R2 psc0 on at 2", main_o[0], 1'b1);
    cnt = 16'd20; tick(4);
  endtask

  task automatic t_short();
    logic seen;
    seen = 1'b0;
    dt = 10'd3; psc = 2'd0;
    cnt = 16'd0; tick(); seen |= main_o[0];
    tick(); seen |= main_o[0];
    cnt = 16'd20;
    for (int i = 0; i < 6; i++) begin
      tick(); seen |= main_o[0];
    end
    chk("R3 short pulse no main", seen, 1'b0);
    chk("R3 comp recovers", comp_o[0], 1'b1);
    dt = '0;
    tick(2);
  endtask

  task automatic t_pol();
    pol_m = 3'b001; pol_c = 3'b001;
    cnt = 16'd0; tick();
    chk("R4 active low ref=1", {main_o[0], comp_o[0]}, 2'b01);
    cnt = 16'd20; tick();
    chk("R4 active low ref=0", {main_o[0], comp_o[0]}, 2'b10);
    pol_m = '0; pol_c = '0;
    cnt = 16'd0; tick();
  endtask

  task automatic t_brk_filter();
    chk("R5 running before", main_o, 3'b011);
    brk_flt = {4'd0, 4'd3};
    brk[0] = 1'b1; tick(2);
    brk[0] = 1'b0; tick();
    brk[0] = 1'b1; tick(2);
    chk("R5 interrupted run", main_o, 3'b011);
    tick();
    chk("R5 R7 main safe", main_o, 3'b101);
    chk("R7 comp safe", comp_o, 3'b010);
    brk[0] = 1'b0; tick(3);
    chk("R7 stays safe", main_o, 3'b101);
    pulse_moe();
    chk("R8 set restores", main_o, 3'b011);
  endtask

  task automatic t_brk_pol();
    brk_pol[1] = 1'b1; brk[1] = 1'b1; tick(3);
    chk("R6 high inactive", main_o, 3'b011);
    brk[1] = 1'b0; tick();
    chk("R6 low active", main_o, 3'b101);
    brk[1] = 1'b1; tick(2);
    pulse_moe();
    chk("R6 restore", main_o, 3'b011);
  endtask

  task automatic t_auto();
    brk_flt = '0;
    brk[0] = 1'b1; tick();
    chk("R7 brake n=1", main_o, 3'b101);
    brk[0] = 1'b0; tick();
    upd = 1'b1; tick(); upd = 1'b0;
    chk("R8 upd ignored auto=0", main_o, 3'b101);
    auto_oe = 1'b1;
    upd = 1'b1; tick(); upd = 1'b0;
    chk("R8 auto restore", main_o, 3'b011);
    brk[0] = 1'b1; tick();
    upd = 1'b1; tick();
    chk("R8 brake beats upd", main_o, 3'b101);
    brk[0] = 1'b0; tick();
    chk("R8 wait one update", main_o, 3'b101);
    tick();
    chk("R8 auto after release", main_o, 3'b011);
    upd = 1'b0; auto_oe = 1'b0;
  endtask

  task automatic t_offrun();
    ch_en = 3'b110; #1;
    chk("R10 inactive lvl", {main_o[0], comp_o[0]}, 2'b00);
    chk("R10 en run=1", men, 3'b111);
    pol_m = 3'b001; pol_c = 3'b001; #1;
    chk("R10 lvl = pol", {main_o[0], comp_o[0]}, 2'b11);
    off_run = 1'b0; #1;
    chk("R10 en run=0", {men, cen}, 6'b110110);
    chk("R12 other ch", main_o[2:1], 2'b01);
    off_run = 1'b1; pol_m = '0; pol_c = '0; ch_en = 3'b111;
  endtask

  initial begin
    tick(2);
    rst_ni = 1'b1;
    tick();
    t_reset();
    t_pwm();
    t_deadtime();
    t_short();
    t_pol();
    t_brk_filter();
    t_brk_pol();
    t_auto();
    t_offrun();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++; n_fail++;
      $display("FAIL watchdog act=running exp=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule